// File: doc/BRIEF.md
# Registered Four-Bit Add/Subtract Accumulator

A small clocked arithmetic unit. Two operand registers each capture their own data input, but only on a cycle where that operand's capture strobe is high. Otherwise they keep their contents, whatever the data inputs do.

A separate compute strobe makes the unit form the sum or the difference of the two stored operands. The operation input picks which one. The 4-bit result and a carry flag are written into output registers, and those registers drive the ports directly.

All state changes on the rising clock edge. A synchronous clear sets every register to zero and wins over every other strobe.

The carry flag has two meanings. When adding, it is the carry out of the top bit. When subtracting, it means no borrow occurred, that is, the first operand is greater than or equal to the second (unsigned).

Top module: `addsub_accum`

## Requirements
- R1: While `clear` is high at a rising edge, both operand registers, `total` and `cflag` become 0, regardless of `cap_x`, `cap_y` and `go`.
- R2: When `cap_x` is high at a rising edge, operand X takes `din_x`; when `cap_y` is high, operand Y takes `din_y`; each holds otherwise.
- R3: Changes on `din_x`/`din_y` while the matching capture strobe is low do not affect stored operands or any later result.
- R4: When `go` is high at a rising edge and `op_sub` is 0, `total` becomes (X+Y) mod 16 and `cflag` the carry out of bit 3.
- R5: When `go` is high and `op_sub` is 1, `total` becomes (X−Y) mod 16 and `cflag` is 1 exactly when X ≥ Y unsigned.
- R6: `total` and `cflag` hold their values on every edge where `go` is low.
- R7: When a capture strobe and `go` are high at the same edge, the result uses the operand values held before that edge.
- R8: `total` and `cflag` change only at rising edges; there is no combinational path from inputs to outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear | input | 1 | Synchronous clear, active high |
| cap_x | input | 1 | Capture strobe for operand X |
| cap_y | input | 1 | Capture strobe for operand Y |
| go | input | 1 | Compute strobe |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| din_x | input | W | Data for operand X |
| din_y | input | W | Data for operand Y |
| total | output | W | Registered result |
| cflag | output | 1 | Registered carry / no-borrow flag |

## Verification
A captured operand is visible to a compute strobe issued in the following cycle. The result appears on `total` and `cflag` one edge after the edge that samples `go`. Each task therefore drives its strobes on a falling edge, lets exactly one rising edge pass, and samples on the next falling edge. Hold and "no effect" checks sample again after further edges with `go` low, to confirm nothing moved.

// File: rtl/addsub_accum.sv
module addsub_accum #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         cap_x,
  input  logic         cap_y,
  input  logic         go,
  input  logic         op_sub,
  input  logic [W-1:0] din_x,
  input  logic [W-1:0] din_y,
  output logic [W-1:0] total,
  output logic         cflag
);
  logic [W-1:0] opx, opy;
  logic [W:0]   wide;

  assign wide = {1'b0, opx} + {1'b0, (op_sub ? ~opy : opy)} + {{W{1'b0}}, op_sub};

  always_ff @(posedge clk) begin
    if (clear) begin
      opx <= '0;
      opy <= '0;
      total <= '0;
      cflag <= 1'b0;
    end else begin
      if (cap_x) opx <= din_x;
      if (cap_y) opy <= din_y;
      if (go) begin
        total <= wide[W-1:0];
        cflag <= wide[W];
      end
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) clear |=> (total == '0 && cflag == 1'b0));
  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (clear) !go |=> ($stable(total) && $stable(cflag)));
  // R4
  add_result_chk: assert property (@(posedge clk) disable iff (clear)
    (go && !op_sub) |=> ({cflag, total} == {1'b0, $past(opx)} + {1'b0, $past(opy)}));
  // R5
  sub_result_chk: assert property (@(posedge clk) disable iff (clear)
    (go && op_sub) |=> (total == W'($past(opx) - $past(opy)) && cflag == ($past(opx) >= $past(opy))));
  // R2
  cap_x_chk: assert property (@(posedge clk) disable iff (clear) cap_x |=> opx == $past(din_x));
endmodule

// File: tb/addsub_accum_test.sv
`timescale 1ns/1ps
module addsub_accum_test;
  logic clk = 0, clear, cap_x, cap_y, go, op_sub;
  logic [3:0] din_x, din_y;
  logic [3:0] total;
  logic cflag;
  int checks = 0, fails = 0;
  bit done = 0;

  addsub_accum #(.W(4)) uut (.clk(clk), .clear(clear), .cap_x(cap_x), .cap_y(cap_y),
    .go(go), .op_sub(op_sub), .din_x(din_x), .din_y(din_y), .total(total), .cflag(cflag));

  always #4 clk = ~clk;

  task automatic check(string req, logic [3:0] et, logic ec);
    checks++;
    if (total !== et || cflag !== ec) begin
      fails++;
      $display("FAIL %s total=%h cflag=%b expected total=%h cflag=%b", req, total, cflag, et, ec);
    end
  endtask

  task automatic step(); @(posedge clk); @(negedge clk); endtask

  task automatic load(logic [3:0] x, logic [3:0] y, bit lx, bit ly);
    din_x = x; din_y = y; cap_x = lx; cap_y = ly; step(); cap_x = 0; cap_y = 0;
  endtask

  task automatic exec(bit s);
    op_sub = s; go = 1; step(); go = 0;
  endtask

  task automatic t_reset();
    clear = 1; step(); clear = 0;
    check("R1 reset", 4'h0, 0);
  endtask

  task automatic t_add();
    load(3, 5, 1, 1); exec(0); check("R4 3+5", 4'h8, 0);
    load(9, 8, 1, 1); exec(0); check("R4 9+8 carry", 4'h1, 1);
    load(15, 1, 1, 1); exec(0); check("R4 15+1", 4'h0, 1);
  endtask

  task automatic t_sub();
    load(3, 5, 1, 1); exec(1); check("R5 3-5", 4'hE, 0);
    load(8, 5, 1, 1); exec(1); check("R5 8-5", 4'h3, 1);
    load(7, 7, 1, 1); exec(1); check("R5 7-7 equal", 4'h0, 1);
    load(0, 15, 1, 1); exec(1); check("R5 0-15", 4'h1, 0);
  endtask

  task automatic t_hold();
    load(3, 5, 1, 1); exec(0);
    din_x = 9; din_y = 2; op_sub = 1; step(); step();
    check("R6 hold no go", 4'h8, 0);
    exec(0); check("R3 ignored inputs", 4'h8, 0);
    load(0, 2, 0, 1); exec(0); check("R2 only Y loaded", 4'h5, 0);
  endtask

  task automatic t_same_edge();
    load(4, 4, 1, 1);
    din_x = 10; cap_x = 1; op_sub = 0; go = 1; step(); cap_x = 0; go = 0;
    check("R7 old operand used", 4'h8, 0);
    exec(0); check("R7 new operand after", 4'hE, 0);
  endtask

  task automatic t_clear_priority();
    load(9, 9, 1, 1); exec(0);
    din_x = 5; din_y = 6; cap_x = 1; cap_y = 1; go = 1; clear = 1; step();
    cap_x = 0; cap_y = 0; go = 0; clear = 0;
    check("R1 clear wins", 4'h0, 0);
    exec(0); check("R1 operands cleared", 4'h0, 0);
  endtask

  task automatic t_comb();
    load(2, 1, 1, 1); exec(0);
    op_sub = 1; go = 1; #1; check("R8 no comb path", 4'h3, 0); @(posedge clk); #1; go = 0;
    @(negedge clk); check("R8 edge update", 4'h1, 1);
  endtask

  initial begin
    clear = 0; cap_x = 0; cap_y = 0; go = 0; op_sub = 0; din_x = 0; din_y = 0;
    @(negedge clk);
    t_reset(); t_add(); t_sub(); t_hold(); t_same_edge(); t_clear_priority(); t_comb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule